// File: doc/BRIEF.md
# Goldschmidt Fractional Divider with a Shared Pipelined Multiplier

This block divides one unsigned fraction by another using Goldschmidt's convergence method. The two operands arrive as IN_W-bit fractions with the binary point above their most significant bit. The divisor must be normalized, meaning its top bit is set, so its value lies in [0.5, 1). Internally both operands are widened to PREC fraction bits with zero padding. Each refinement step multiplies a numerator register and a denominator register by the same factor. The factor is roughly two minus the current denominator. As the denominator approaches one, the numerator approaches the quotient.

Only one multiplier is used. It has two pipeline stages, and the numerator product and the denominator product of a step go through it one after the other. The factor is the one's complement of the denominator with an implied leading one. The early steps keep only the top 2, 4, 8, ... bits of that complement. A final step uses the full PREC-bit complement. The dividend is halved on entry, so the quotient comes out with one integer bit and PREC-1 fraction bits and can cover the full range [0, 2).

A caller pulses `start` with the operands while the block is idle. When `done` pulses, `quotient` holds the result, and it stays there until the next result replaces it.

Top module: `frac_gs_divider`

## Requirements
- R1: While `rst` is high (synchronous, active high), and in the cycle after it, `busy` is 0, `done` is 0 and `quotient` is 0.
- R2: A `start` sampled high on a rising edge while `busy` is low captures `dividend` and `divisor`, and `busy` reads 1 from the next cycle. This includes the cycle in which `done` is high.
- R3: `done` is high for exactly one cycle, 4*(clog2(PREC)+1) rising edges after the edge that accepted `start` (20 for PREC=16). `busy` drops in that same cycle.
- R4: When the divisor's bit IN_W-1 is 1, `quotient`, read as an unsigned number with PREC-1 fraction bits, is within 10 LSB of dividend*2^(PREC-1)/divisor, where both operands are taken as plain integers.
- R5: A zero dividend gives a `quotient` of exactly 0.
- R6: A `start` while `busy` is high is ignored. The running division keeps its operands and its timing, and no extra result follows.
- R7: `quotient` changes only in a cycle where `done` is high. Between pulses it holds the last result, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division using the present operands |
| dividend | input | IN_W | Dividend fraction, binary point above the MSB |
| divisor | input | IN_W | Divisor fraction, MSB must be 1 |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: quotient has just been updated |
| quotient | output | PREC | Quotient, 1 integer bit and PREC-1 fraction bits |

## Verification
The result is due a fixed number of edges after the accepting edge: four per step, with clog2(PREC)+1 steps. `busy` is due one edge after acceptance. The bench's behavioural model counts edges from each accepted `start`. On every falling edge it compares `busy` and `done` with that count. It checks the quotient against the exact integer ratio in the cycle where `done` is expected, and against the last held value in every other cycle. Starts issued during a run, and starts issued in the `done` cycle itself, are placed at known edges, so the model predicts exactly whether each one is dropped or accepted.

// File: rtl/gs_div_pkg.sv
package gs_div_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // Number of complement bits used as the factor in a given step:
  // the width doubles each step, and the last step uses all of them.
  function automatic int step_factor_bits(input int step, input int prec, input int nsteps);
    int w;
    if (step >= nsteps - 1) return prec;
    w = 2 << step;
    return (w > prec) ? prec : w;
  endfunction

endpackage

// File: rtl/gs_mult_pipe.sv
// Two-stage multiplier shared by the numerator and denominator updates.
// Stage 1 registers the full product; stage 2 registers the slice that
// keeps PREC fraction bits, truncating the rest.
module gs_mult_pipe #(
  parameter int PREC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic            in_tag,
  input  logic [PREC-1:0] opa,
  input  logic [PREC:0]   opb,
  output logic            out_vld,
  output logic            out_tag,
  output logic [PREC-1:0] out_q
);
  localparam int PW = 2 * PREC + 1;

  logic [PW-1:0] s1_prod;
  logic          s1_vld, s1_tag;
  logic          unused_low;

  assign unused_low = ^s1_prod[PREC-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_tag  <= 1'b0;
      s1_prod <= '0;
      out_vld <= 1'b0;
      out_tag <= 1'b0;
      out_q   <= '0;
    end else begin
      s1_vld  <= in_vld;
      s1_tag  <= in_tag;
      s1_prod <= {{(PREC+1){1'b0}}, opa} * {{PREC{1'b0}}, opb};
      out_vld <= s1_vld;
      out_tag <= s1_tag;
      out_q   <= s1_prod[2*PREC-1:PREC];
    end
  end

  // R4: a product never reaches one, so the truncation loses no integer part
  prod_int_zero_chk: assert property (@(posedge clk) disable iff (rst)
    s1_vld |-> !s1_prod[PW-1]);

endmodule

// File: rtl/gs_factor_gen.sv
// Builds the step factor 1.f, where f is the one's complement of the
// denominator kept only in its top step_factor_bits() positions.
module gs_factor_gen #(
  parameter int PREC   = 16,
  parameter int NSTEP  = 5,
  parameter int STEP_W = 3
) (
  input  logic [PREC-1:0]   den,
  input  logic [STEP_W-1:0] step,
  output logic [PREC:0]     factor
);
  import gs_div_pkg::*;

  localparam logic [PREC-1:0] ALL_ONES = {PREC{1'b1}};

  logic [PREC-1:0] mask_tbl [NSTEP];
  logic [PREC-1:0] sel_mask;

  for (genvar s = 0; s < NSTEP; s++) begin : g_mask
    localparam int KEEP = step_factor_bits(s, PREC, NSTEP);
    assign mask_tbl[s] = ~(ALL_ONES >> KEEP);
  end

  always_comb begin
    sel_mask = '0;
    for (int s = 0; s < NSTEP; s++) begin
      if (step == STEP_W'(s)) sel_mask = mask_tbl[s];
    end
  end

  assign factor = {1'b1, (~den) & sel_mask};

endmodule

// File: rtl/gs_seq_ctrl.sv
// Step/phase sequencer. Each step takes four cycles:
// phase 0 issue numerator, 1 issue denominator, 2 numerator returns,
// 3 denominator returns.
module gs_seq_ctrl #(
  parameter int NSTEP  = 5,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              accept,
  output logic              issue_vld,
  output logic              issue_tag,
  output logic              running,
  output logic              finish,
  output logic [STEP_W-1:0] step,
  output logic [1:0]        phase,
  output logic              busy,
  output logic              done
);
  import gs_div_pkg::*;

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSTEP - 1);

  seq_state_t st;

  assign running   = (st == SEQ_RUN);
  assign accept    = (st == SEQ_IDLE) && start;
  assign issue_vld = running && !phase[1];
  assign issue_tag = phase[0];
  assign finish    = running && (phase == 2'd3) && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SEQ_IDLE;
      step  <= '0;
      phase <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st    <= SEQ_RUN;
            step  <= '0;
            phase <= '0;
            busy  <= 1'b1;
          end
        end
        SEQ_RUN: begin
          phase <= phase + 2'd1;
          if (phase == 2'd3) begin
            if (step == LAST_STEP) begin
              st   <= SEQ_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              step <= step + STEP_W'(1);
            end
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  // R3: the completion pulse lasts a single cycle
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: busy is already low when done is shown
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: an idle block answers a start with busy on the next cycle
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

endmodule

// File: rtl/frac_gs_divider.sv
module frac_gs_divider #(
  parameter int IN_W = 8,
  parameter int PREC = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [IN_W-1:0] dividend,
  input  logic [IN_W-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [PREC-1:0] quotient
);
  localparam int NSTEP  = $clog2(PREC) + 1;
  localparam int STEP_W = $clog2(NSTEP) > 0 ? $clog2(NSTEP) : 1;
  localparam int PAD    = PREC - IN_W;

  logic [PREC-1:0]   num_q, den_q;
  logic [PREC-1:0]   num_init, den_init;
  logic [PREC:0]     factor;
  logic [PREC-1:0]   mul_a;
  logic              accept, issue_vld, issue_tag, running, finish;
  logic [STEP_W-1:0] step;
  logic [1:0]        phase;
  logic              wb_vld, wb_tag;
  logic [PREC-1:0]   wb_q;
  logic              chk_armed;

  // Dividend is halved on entry so the quotient fits 1.(PREC-1) format.
  assign num_init = {{PAD{1'b0}}, dividend} << (PAD - 1);
  assign den_init = {{PAD{1'b0}}, divisor} << PAD;

  gs_seq_ctrl #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .accept    (accept),
    .issue_vld (issue_vld),
    .issue_tag (issue_tag),
    .running   (running),
    .finish    (finish),
    .step      (step),
    .phase     (phase),
    .busy      (busy),
    .done      (done)
  );

  gs_factor_gen #(.PREC(PREC), .NSTEP(NSTEP), .STEP_W(STEP_W)) u_factor (
    .den    (den_q),
    .step   (step),
    .factor (factor)
  );

  assign mul_a = issue_tag ? den_q : num_q;

  gs_mult_pipe #(.PREC(PREC)) u_mult (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (issue_vld),
    .in_tag  (issue_tag),
    .opa     (mul_a),
    .opb     (factor),
    .out_vld (wb_vld),
    .out_tag (wb_tag),
    .out_q   (wb_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q    <= '0;
      den_q    <= '0;
      quotient <= '0;
    end else begin
      if (accept) begin
        num_q <= num_init;
        den_q <= den_init;
      end else if (wb_vld) begin
        if (wb_tag) den_q <= wb_q;
        else        num_q <= wb_q;
      end
      if (finish) quotient <= num_q;
    end
  end

  always_ff @(posedge clk) chk_armed <= !rst;

  // R3: each product returns in the phase reserved for its register
  wb_align_chk: assert property (@(posedge clk) disable iff (rst)
    wb_vld |-> (running && phase == {1'b1, wb_tag}));

  // R4: the denominator never moves away from one
  den_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_vld && wb_tag) |-> (wb_q >= den_q));

  // R7: the result register moves only together with the done pulse
  quo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && !done) |-> $stable(quotient));

endmodule

// File: tb/frac_gs_divider_test.sv
module frac_gs_divider_test;
  localparam int IN_W       = 8;
  localparam int PREC       = 16;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP      = $clog2(PREC) + 1;
  localparam int LAT        = 4 * NSTEP;
  localparam int TOL        = 10;
  localparam int WD_LIMIT   = 100000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [IN_W-1:0] dvd = '0;
  logic [IN_W-1:0] dvs = 8'h80;
  logic            busy, done;
  logic [PREC-1:0] quotient;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model state
  bit              m_busy = 0, m_done = 0, m_zero = 0;
  int              m_cnt = 0;
  longint          m_exp = 0;
  logic [PREC-1:0] hold_q = '0;

  frac_gs_divider #(.IN_W(IN_W), .PREC(PREC)) uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dvd), .divisor(dvs),
    .busy(busy), .done(done), .quotient(quotient)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic longint exact_q(input logic [IN_W-1:0] x, input logic [IN_W-1:0] y);
    return (longint'(x) << (PREC - 1)) / longint'(y);
  endfunction

  // model: accepts a start only when idle, result after LAT edges
  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1; m_cnt <= 0;
          m_exp  <= exact_q(dvd, dvs);
          m_zero <= (dvd == 0);
        end
      end else if (m_cnt == LAT - 1) begin
        m_busy <= 0; m_done <= 1;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    longint diff;
    if (rst) begin
      hold_q = '0;
    end else begin
      check(busy === m_busy, "R2 busy", longint'(busy), longint'(m_busy));
      check(done === m_done, "R3 done", longint'(done), longint'(m_done));
      if (m_done) begin
        if (m_zero) begin
          check(quotient === '0, "R5 zero dividend", longint'(quotient), 0);
        end else begin
          diff = longint'(quotient) - m_exp;
          check(diff <= TOL && diff >= -TOL, "R4 quotient", longint'(quotient), m_exp);
        end
        hold_q = quotient;
      end else begin
        check(quotient === hold_q, "R7 hold", longint'(quotient), longint'(hold_q));
      end
    end
  end

  // one division: start at this falling edge, return at the done cycle
  task automatic run_div(input logic [IN_W-1:0] x, input logic [IN_W-1:0] y);
    start = 1'b1; dvd = x; dvs = y;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0, "R1 busy", longint'(busy), 0);
    check(done === 1'b0, "R1 done", longint'(done), 0);
    check(quotient === '0, "R1 quotient", longint'(quotient), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && quotient === '0, "R1 after release",
          longint'(quotient), 0);

    // directed corners (R4, R5); each next start lands in the done cycle (R2)
    run_div(8'h80, 8'h80);
    check(longint'(quotient) >= exact_q(8'h80, 8'h80) - TOL, "R4 x=y", longint'(quotient),
          exact_q(8'h80, 8'h80));
    run_div(8'hFF, 8'h80);
    run_div(8'h00, 8'hC3);
    check(quotient === '0, "R5 direct", longint'(quotient), 0);
    run_div(8'h01, 8'hFF);
    run_div(8'hFF, 8'hFF);
    run_div(8'hAA, 8'h81);
    run_div(8'h80, 8'hFF);

    // R7: idle with changing inputs, no start
    for (int i = 0; i < 12; i++) begin
      dvd = 8'(i * 37); dvs = 8'h80 | 8'(i * 11);
      @(negedge clk);
    end
    check(quotient === hold_q, "R7 idle", longint'(quotient), longint'(hold_q));

    // R6: start during a run with other operands is ignored
    start = 1'b1; dvd = 8'h40; dvs = 8'hC0;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; dvd = 8'hFF; dvs = 8'h80;
    @(negedge clk);
    start = 1'b0;
    repeat (LAT - 5) @(negedge clk);
    check(done === 1'b1, "R6 timing kept", longint'(done), 1);
    begin
      longint d6;
      d6 = longint'(quotient) - exact_q(8'h40, 8'hC0);
      check(d6 <= TOL && d6 >= -TOL, "R6 operands kept", longint'(quotient),
            exact_q(8'h40, 8'hC0));
    end
    repeat (LAT + 4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R6 no extra run", longint'(busy), 0);

    // random normalized divisors (R4)
    for (int k = 0; k < 150; k++) begin
      run_div(8'($urandom), 8'h80 | 8'($urandom));
      if (k % 7 == 3) repeat (k % 5) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WD_LIMIT);
    finish_up();
  end

endmodule